// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block collects the event flags of a serial bus controller and turns them into one level-sensitive interrupt line and two DMA request lines. One request line serves receive and the other serves transmit. The data path and the transfer sequencer report events as single-cycle set pulses. Each pulse sets a sticky flag. Software reads the flags through a small 16-bit register port, together with a live bus-busy indication.

A 5-bit enable mask selects which of the low flags may raise the interrupt. A vector register reports the lowest pending enabled event as a one-based number. Reading the vector register also acknowledges that event, so an interrupt handler can loop on the vector register until it reads zero. A DMA-enable register routes the receive-ready and transmit-ready flags to the DMA request lines. Turning on DMA for a direction also clears that direction's interrupt enable, so the same event does not reach both the DMA engine and the interrupt line.

Register map (word offsets on `reg_addr`):
- 0: identity
- 1: enable mask
- 2: status
- 3: vector
- 4: DMA enable

Flag bit positions:
- 1: no-acknowledge
- 2: access ready
- 3: receive ready
- 4: transmit ready
- 9: addressed as target
- 10: transmit underflow
- 11: receive overrun
- 15: single byte left

Top module: `evt_irq_unit`

## Requirements
- R1: After a synchronous active-high reset, the mask, all flags and both DMA enables are zero. The irq, rx_dma_req and tx_dma_req outputs are low. Reading offsets 1, 2 (with bus idle), 3 and 4 returns 0x0000.
- R2: A 1 on evt_set bit 1, 2, 3, 4, 9, 10, 11 or 15 sets the matching flag at the next clock edge. The flag stays set until it is acknowledged. Pulses on any other evt_set bit have no effect, so the status register can never show more than 0x8E1E.
- R3: irq is high exactly when a flag in bits 4..0 is set and its mask bit is also set. It follows the registered state, one cycle after the set pulse or the register write.
- R4: A read of offset 2 returns the flags, with bus_busy placed at bit 12.
- R5: Offset 3 shows the one-based position of the lowest set bit of (flags[4:0] AND mask), or 0 when that value is zero. When reg_rd is high at offset 3, the flag it names is cleared at the clock edge. Exactly one flag is cleared, and only on such a read.
- R6: A set pulse for a flag that a vector read clears in the same cycle wins, so the flag stays set.
- R7: A write to offset 1 stores bits 4..0 of reg_wdata as the mask. A read of offset 1 returns the mask with the upper bits zero.
- R8: A write to offset 4 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable), so reads return reg_wdata AND 0x8080. Writing 1 to bit 15 clears mask bit 3. Writing 1 to bit 7 clears mask bit 4.
- R9: rx_dma_req equals flag 3 while receive DMA is enabled. tx_dma_req equals flag 4 while transmit DMA is enabled. Each request line is low while its DMA enable is off.
- R10: Writes to offsets 0, 2 and 3 change no state. Offset 0 always reads the identity value 0x0021, and offsets 5 to 7 read 0x0000.
- R11: A vector read with nothing pending and enabled returns 0 and leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has a side effect only at the vector offset) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| evt_set | input | 16 | Flag set pulses, one bit per flag position |
| bus_busy | input | 1 | Live bus-busy level, shown at status bit 12 |
| irq | output | 1 | Level interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The properties assume a single register port: a read and a write in the same cycle share reg_addr, and only a read strobe at the vector offset has a side effect. The stability checks after a read-only write also assume that no set pulse and no vector acknowledge arrive in that cycle, so the properties exclude those cycles instead of constraining the inputs. The stimulus drives inputs one time unit after each rising edge. It mixes sparse random set pulses with register traffic over all eight offsets, including vector reads that coincide with set pulses for the flag being acknowledged.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
  localparam int VEC_W = 16;

  // One-based position of the lowest set bit, zero when none.
  function automatic logic [VEC_W-1:0] lowest_one_based(input logic [VEC_W-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (v[i]) r = VEC_W'(i + 1);
    end
    return r;
  endfunction

  // Turn a one-based position back into a one-hot clear mask.
  function automatic logic [VEC_W-1:0] onehot_from_index(input logic [VEC_W-1:0] idx);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = 0; i < VEC_W; i++) begin
      if (idx == VEC_W'(i + 1)) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eiu_flags.sv
module eiu_flags #(
  parameter int          DATA_W    = 16,
  parameter logic [15:0] FLAG_IMPL = 16'h8E1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] flags_q
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (FLAG_IMPL[b]) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)           flags_q[b] <= 1'b0;
        else if (set_i[b]) flags_q[b] <= 1'b1;
        else if (clr_i[b]) flags_q[b] <= 1'b0;
      end
    end else begin : g_tie
      assign flags_q[b] = 1'b0;
      wire unused_b = set_i[b] | clr_i[b];
    end
  end
endmodule

// File: rtl/eiu_ctrl.sv
module eiu_ctrl #(
  parameter int EN_W    = 5,
  parameter int RX_FLAG = 3,
  parameter int TX_FLAG = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_mask,
  input  logic            wr_dma,
  input  logic [EN_W-1:0] mask_wdata,
  input  logic            rx_en_wdata,
  input  logic            tx_en_wdata,
  output logic [EN_W-1:0] mask_q,
  output logic            rx_en_q,
  output logic            tx_en_q
);
  logic [EN_W-1:0] dma_strip;

  always_comb begin
    dma_strip = '1;
    if (rx_en_wdata) dma_strip[RX_FLAG] = 1'b0;
    if (tx_en_wdata) dma_strip[TX_FLAG] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else if (wr_mask) begin
      mask_q <= mask_wdata;
    end else if (wr_dma) begin
      rx_en_q <= rx_en_wdata;
      tx_en_q <= tx_en_wdata;
      mask_q  <= mask_q & dma_strip;
    end
  end
endmodule

// File: rtl/eiu_vector.sv
module eiu_vector #(
  parameter int DATA_W = 16,
  parameter int EN_W   = 5
) (
  input  logic [DATA_W-1:0] flags,
  input  logic [EN_W-1:0]   mask,
  input  logic              ack,
  output logic [DATA_W-1:0] vec_idx,
  output logic [DATA_W-1:0] clr
);
  import eiu_pkg::*;
  logic [DATA_W-1:0] pending;

  assign pending = {{(DATA_W-EN_W){1'b0}}, flags[EN_W-1:0] & mask};
  assign vec_idx = lowest_one_based(pending);
  assign clr     = ack ? onehot_from_index(vec_idx) : '0;

  wire unused_hi = |flags[DATA_W-1:EN_W];
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit #(
  parameter int          DATA_W     = 16,
  parameter int          ADDR_W     = 3,
  parameter int          EN_W       = 5,
  parameter logic [15:0] ID_VALUE   = 16'h0021,
  parameter logic [15:0] FLAG_IMPL  = 16'h8E1E,
  parameter int          BUSY_POS   = 12,
  parameter int          RX_FLAG    = 3,
  parameter int          TX_FLAG    = 4,
  parameter int          RXDMA_POS  = 15,
  parameter int          TXDMA_POS  = 7,
  parameter int          OFS_ID     = 0,
  parameter int          OFS_MASK   = 1,
  parameter int          OFS_STATUS = 2,
  parameter int          OFS_VECTOR = 3,
  parameter int          OFS_DMA    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] evt_set,
  input  logic              bus_busy,
  output logic              irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req
);
  localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(OFS_VECTOR);
  localparam logic [ADDR_W-1:0] A_DMA = ADDR_W'(OFS_DMA);

  // Named internal events, brought out for the bound checker
  logic [DATA_W-1:0] status_q;
  logic [EN_W-1:0]   mask_q;
  logic              dma_rx_en;
  logic              dma_tx_en;
  logic [DATA_W-1:0] vec_idx;
  logic [DATA_W-1:0] vec_clr;
  logic              vec_ack;
  logic              wr_mask;
  logic              wr_dma;

  assign vec_ack = reg_rd && (reg_addr == A_VEC);
  assign wr_mask = reg_wr && (reg_addr == A_MSK);
  assign wr_dma  = reg_wr && (reg_addr == A_DMA);

  eiu_flags #(.DATA_W(DATA_W), .FLAG_IMPL(FLAG_IMPL)) u_flags (
    .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(vec_clr), .flags_q(status_q)
  );

  eiu_ctrl #(.EN_W(EN_W), .RX_FLAG(RX_FLAG), .TX_FLAG(TX_FLAG)) u_ctrl (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_dma(wr_dma),
    .mask_wdata(reg_wdata[EN_W-1:0]),
    .rx_en_wdata(reg_wdata[RXDMA_POS]), .tx_en_wdata(reg_wdata[TXDMA_POS]),
    .mask_q(mask_q), .rx_en_q(dma_rx_en), .tx_en_q(dma_tx_en)
  );

  eiu_vector #(.DATA_W(DATA_W), .EN_W(EN_W)) u_vec (
    .flags(status_q), .mask(mask_q), .ack(vec_ack),
    .vec_idx(vec_idx), .clr(vec_clr)
  );

  assign irq        = |(status_q[EN_W-1:0] & mask_q);
  assign rx_dma_req = dma_rx_en & status_q[RX_FLAG];
  assign tx_dma_req = dma_tx_en & status_q[TX_FLAG];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ID:  reg_rdata = ID_VALUE;
      A_MSK: reg_rdata = {{(DATA_W-EN_W){1'b0}}, mask_q};
      A_ST: begin
        reg_rdata = status_q;
        reg_rdata[BUSY_POS] = bus_busy;
      end
      A_VEC: reg_rdata = vec_idx;
      A_DMA: begin
        reg_rdata[RXDMA_POS] = dma_rx_en;
        reg_rdata[TXDMA_POS] = dma_tx_en;
      end
      default: reg_rdata = '0;
    endcase
  end

  wire unused_wdata = &{1'b0, reg_wdata};
endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int EN_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] evt_set,
  input logic              irq,
  input logic              rx_dma_req,
  input logic              tx_dma_req,
  input logic [DATA_W-1:0] status_q,
  input logic [EN_W-1:0]   mask_q,
  input logic              dma_rx_en,
  input logic              dma_tx_en,
  input logic [DATA_W-1:0] vec_clr
);
  logic [1:0] rst_seen = 2'd0;
  logic       rst_prev = 1'b0;
  always @(posedge clk) begin
    if (rst && rst_seen != 2'd3) rst_seen <= rst_seen + 2'd1;
    rst_prev <= rst;
  end
  wire off = rst || (rst_seen < 2'd2);

  always @(posedge clk) begin
    if (!rst && rst_prev && rst_seen >= 2'd1)
      AST_RESET_CLEAN: assert (status_q == '0 && mask_q == '0 && !dma_rx_en && !dma_tx_en && !irq); // R1
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (off)
    (evt_set[1] |=> status_q[1])); // R2
  AST_NO_SPONTANEOUS_FLAG: assert property (@(posedge clk) disable iff (off)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_set)) == '0)); // R2
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (off)
    irq |-> (mask_q != '0 && status_q[EN_W-1:0] != '0)); // R3
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (off)
    $onehot0(vec_clr)); // R5
  AST_CLEAR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (off)
    !(reg_rd && reg_addr == 3'd3) |-> (vec_clr == '0)); // R5
  AST_VECTOR_CLEARS: assert property (@(posedge clk) disable iff (off)
    ((vec_clr != '0) && ((vec_clr & evt_set) == '0)) |=> ((status_q & $past(vec_clr)) == '0)); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (off)
    ((vec_clr & evt_set) != '0) |=> ((status_q & $past(vec_clr)) != '0)); // R6
  AST_DMA_STRIPS_MASK: assert property (@(posedge clk) disable iff (off)
    (reg_wr && reg_addr == 3'd4 && reg_wdata[15]) |=> !mask_q[3]); // R8
  AST_RX_REQ_GATED: assert property (@(posedge clk) disable iff (off)
    rx_dma_req |-> (dma_rx_en && status_q[3])); // R9
  AST_TX_REQ_GATED: assert property (@(posedge clk) disable iff (off)
    tx_dma_req |-> (dma_tx_en && status_q[4])); // R9
  AST_RO_WRITE_STABLE: assert property (@(posedge clk) disable iff (off)
    (reg_wr && reg_addr == 3'd2 && evt_set == '0 && !reg_rd) |=> ($stable(status_q) && $stable(mask_q))); // R10
endmodule

bind evt_irq_unit evt_irq_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_W(EN_W)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .evt_set(evt_set), .irq(irq), .rx_dma_req(rx_dma_req),
  .tx_dma_req(tx_dma_req), .status_q(status_q), .mask_q(mask_q),
  .dma_rx_en(dma_rx_en), .dma_tx_en(dma_tx_en), .vec_clr(vec_clr)
);

// File: tb/evt_irq_unit_test.sv
`timescale 1ns/1ps
module evt_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] evt_set = '0;
  logic        bus_busy = 1'b0;
  logic        irq, rx_dma_req, tx_dma_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit model_live = 0;

  // behavioural reference state
  int m_stat, m_mask, m_dma;

  always #5 clk = ~clk;

  evt_irq_unit uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .bus_busy(bus_busy), .irq(irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  function automatic int first_pending(int s, int m);
    int p = s & m & 'h1F;
    for (int k = 1; k <= 5; k++) if ((p >> (k - 1)) & 1) return k;
    return 0;
  endfunction

  function automatic int expect_read(int a);
    case (a)
      0: return 'h0021;
      1: return m_mask;
      2: return m_stat | (int'(bus_busy) << 12);
      3: return first_pending(m_stat, m_mask);
      4: return m_dma;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      1: return "R7";
      2: return "R4";
      3: return "R5";
      4: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: one update per rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_stat = 0; m_mask = 0; m_dma = 0; model_live = 1;
    end else if (model_live) begin
      int v, nstat;
      nstat = m_stat;
      v = first_pending(m_stat, m_mask);
      if (reg_rd && reg_addr == 3 && v != 0) nstat = nstat & ~(1 << (v - 1));
      nstat = nstat | (int'(evt_set) & 'h8E1E);
      if (reg_wr && reg_addr == 1) m_mask = int'(reg_wdata) & 'h1F;
      if (reg_wr && reg_addr == 4) begin
        m_dma = int'(reg_wdata) & 'h8080;
        if (reg_wdata[15]) m_mask = m_mask & ~8;
        if (reg_wdata[7])  m_mask = m_mask & ~16;
      end
      m_stat = nstat;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (model_live && !rst && !done) begin
      bit eirq, erx, etx;
      eirq = (m_stat & m_mask & 'h1F) != 0;
      erx  = m_dma[15] && m_stat[3];
      etx  = m_dma[7] && m_stat[4];
      check(irq == eirq, "R3", int'(irq), int'(eirq));
      check(rx_dma_req == erx, "R9", int'(rx_dma_req), int'(erx));
      check(tx_dma_req == etx, "R9", int'(tx_dma_req), int'(etx));
      check(int'(reg_rdata) == expect_read(int'(reg_addr)), tag_of(int'(reg_addr)),
            int'(reg_rdata), expect_read(int'(reg_addr)));
    end
  end

  task automatic op(input bit w, input bit r, input int a, input int d, input int s);
    reg_wr = w; reg_rd = r; reg_addr = 3'(a); reg_wdata = 16'(d); evt_set = 16'(s);
    @(posedge clk); #1;
    reg_wr = 0; reg_rd = 0; reg_wdata = '0; evt_set = '0;
  endtask

  task automatic peek(input int a, input int exp, input string req);
    reg_addr = 3'(a);
    @(negedge clk);
    check(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    @(negedge clk);
    check(!irq && !rx_dma_req && !tx_dma_req, "R1", int'({irq, rx_dma_req, tx_dma_req}), 0);
    @(posedge clk); #1;
    peek(1, 0, "R1"); peek(2, 0, "R1"); peek(3, 0, "R1"); peek(4, 0, "R1");
    peek(0, 'h0021, "R10");
    // R2 only implemented flags set
    op(0, 0, 0, 0, 'hFFFF);
    peek(2, 'h8E1E, "R2");
    // R3 irq needs the mask
    @(negedge clk); check(!irq, "R3", int'(irq), 0); @(posedge clk); #1;
    op(1, 0, 1, 'h0004, 0);
    @(negedge clk); check(irq, "R3", int'(irq), 1); @(posedge clk); #1;
    // R7 mask width
    op(1, 0, 1, 'hFFFF, 0);
    peek(1, 'h001F, "R7");
    // R4 busy bit
    bus_busy = 1; peek(2, 'h9E1E, "R4"); bus_busy = 0;
    // R5 vector walk
    peek(3, 2, "R5");
    op(0, 1, 3, 0, 0); peek(3, 3, "R5"); peek(2, 'h8E1C, "R5");
    op(0, 1, 3, 0, 0); peek(3, 4, "R5");
    op(0, 1, 3, 0, 0); peek(3, 5, "R5");
    op(0, 1, 3, 0, 0); peek(3, 0, "R5");
    @(negedge clk); check(!irq, "R5", int'(irq), 0); @(posedge clk); #1;
    // R11 empty vector read
    op(0, 1, 3, 0, 0); peek(2, 'h8E00, "R11");
    // R6 set beats clear
    op(0, 0, 0, 0, 'h0002); peek(3, 2, "R6");
    op(0, 1, 3, 0, 'h0002); peek(2, 'h8E02, "R6");
    // R10 read-only offsets
    op(1, 0, 2, 0, 0); peek(2, 'h8E02, "R10");
    op(1, 0, 3, 'hFFFF, 0); peek(2, 'h8E02, "R10");
    op(1, 0, 0, 0, 0); peek(0, 'h0021, "R10"); peek(6, 0, "R10");
    // R8 DMA write strips mask
    op(1, 0, 4, 'hFFFF, 0);
    peek(4, 'h8080, "R8"); peek(1, 'h0007, "R8");
    // R9 requests
    op(0, 0, 0, 0, 'h0018);
    @(negedge clk);
    check(rx_dma_req && tx_dma_req, "R9", int'({rx_dma_req, tx_dma_req}), 3);
    @(posedge clk); #1;
    op(1, 0, 4, 0, 0);
    @(negedge clk);
    check(!rx_dma_req && !tx_dma_req, "R9", int'({rx_dma_req, tx_dma_req}), 0);
    @(posedge clk); #1;
    // random traffic against the model
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int a, kind;
      a = $urandom_range(0, 7);
      kind = $urandom_range(0, 9);
      bus_busy = 1'($urandom_range(0, 1));
      op(kind < 3, kind >= 3 && kind < 7, a, int'($urandom()) & 'hFFFF,
         ($urandom_range(0, 3) == 0) ? (int'($urandom()) & 'hFFFF) : 0);
    end
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule